// File: doc/BRIEF.md
# Accumulator Register Machine Core

This block is a small processor core with separate program and data memories. Each program cell holds one instruction of twice the data width. The upper half of an instruction is the operation code and the lower half is its argument. The core has an accumulator, two index registers and a program counter. On every clock it fetches the instruction that the program counter addresses and decodes the operation code. It then routes the instruction to one of three places: an arithmetic/logic path, a move path between registers and data memory, or the flow-control logic.

The arithmetic path always combines the accumulator with the immediate argument and writes the result back to the accumulator. The move path transfers values between the accumulator, the index registers and data memory. Both memories are arrays inside the block. A load port writes into them while the core is held in reset. A combinational peek port reads one data cell, so that results can be observed from outside.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, accumulator, both index registers and `halted` to zero on the next rising edge.
- R2: An instruction is the word `{op[2W-1:W], arg[W-1:0]}`. Every executed instruction other than a taken jump or a halt advances the program counter by one, modulo 2^W.
- R3: Opcode 3 loads `arg` into the accumulator. Opcode 4 adds `arg`, opcode 5 subtracts `arg` and opcode 6 ANDs with `arg`. Results wrap modulo 2^W.
- R4: Opcode 1 loads the accumulator from data cell `arg`. Opcode 2 writes the accumulator into data cell `arg` and leaves the accumulator unchanged.
- R5: Opcode 7 copies the accumulator into index register 1. Opcode 8 copies it into index register 2.
- R6: Opcode 9 loads the accumulator from data cell `(IN1 + arg) mod 2^W`.
- R7: Opcode 10 sets the program counter to `arg`. Opcode 11 does the same only when the accumulator is zero; otherwise the program counter advances by one.
- R8: Opcode 15 raises `halted`. From then until reset, the program counter, the registers and data memory do not change.
- R9: Opcode 0 and every opcode not listed above (for example 12, 13, 255) change no register and no data cell; only the program counter advances.
- R10: Program and data memories are separate. A store to data address k does not alter program cell k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables loading |
| ld_prog_en | input | 1 | Write `ld_prog_word` into program cell `ld_addr` |
| ld_data_en | input | 1 | Write `ld_data_val` into data cell `ld_addr` |
| ld_addr | input | W | Load address |
| ld_prog_word | input | 2W | Instruction word to load |
| ld_data_val | input | W | Data value to load |
| peek_addr | input | W | Data cell to observe |
| peek_data | output | W | Contents of data cell `peek_addr` |
| pc_o | output | W | Program counter |
| acc_o | output | W | Accumulator |
| in1_o | output | W | Index register 1 |
| in2_o | output | W | Index register 2 |
| halted | output | 1 | Core has executed a halt |

## Verification
Two cases are the hardest to reach from the ports. The first is an indexed load whose address sum wraps past the top of data memory. The second is a store whose target address is the same as the program address of a later instruction. In both, a wrong design can still look correct unless the test puts a known value at the wrapped cell or runs the instruction that a shared memory would have overwritten. The stimulus loads short programs through the load port while the core is in reset. One program loads an index near the top of the address range and adds an offset that wraps to a preset cell. Another program stores to the address of the instruction that comes next, so the results show whether that instruction ran unchanged.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int unsigned OP_NOP  = 0;
    localparam int unsigned OP_LD   = 1;
    localparam int unsigned OP_ST   = 2;
    localparam int unsigned OP_LDI  = 3;
    localparam int unsigned OP_ADD  = 4;
    localparam int unsigned OP_SUB  = 5;
    localparam int unsigned OP_AND  = 6;
    localparam int unsigned OP_MV1  = 7;
    localparam int unsigned OP_MV2  = 8;
    localparam int unsigned OP_LDX  = 9;
    localparam int unsigned OP_JMP  = 10;
    localparam int unsigned OP_JZ   = 11;
    localparam int unsigned OP_HALT = 15;

    typedef enum logic [1:0] {
        U_NONE = 2'd0,
        U_ALU  = 2'd1,
        U_MOVE = 2'd2,
        U_FLOW = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        F_PASS = 2'd0,
        F_ADD  = 2'd1,
        F_SUB  = 2'd2,
        F_AND  = 2'd3
    } alu_fn_e;

    typedef struct packed {
        unit_e   unit;
        alu_fn_e fn;
        logic    acc_we;
        logic    mem_we;
        logic    in1_we;
        logic    in2_we;
        logic    indexed;
        logic    jump;
        logic    need_zero;
        logic    halt;
    } ctrl_t;

    function automatic ctrl_t classify(input int unsigned code);
        ctrl_t c;
        c = '0;
        c.unit = U_NONE;
        c.fn   = F_PASS;
        case (code)
            OP_LD:   begin c.unit = U_MOVE; c.acc_we = 1'b1; end
            OP_ST:   begin c.unit = U_MOVE; c.mem_we = 1'b1; end
            OP_LDI:  begin c.unit = U_ALU; c.fn = F_PASS; c.acc_we = 1'b1; end
            OP_ADD:  begin c.unit = U_ALU; c.fn = F_ADD;  c.acc_we = 1'b1; end
            OP_SUB:  begin c.unit = U_ALU; c.fn = F_SUB;  c.acc_we = 1'b1; end
            OP_AND:  begin c.unit = U_ALU; c.fn = F_AND;  c.acc_we = 1'b1; end
            OP_MV1:  begin c.unit = U_MOVE; c.in1_we = 1'b1; end
            OP_MV2:  begin c.unit = U_MOVE; c.in2_we = 1'b1; end
            OP_LDX:  begin c.unit = U_MOVE; c.acc_we = 1'b1; c.indexed = 1'b1; end
            OP_JMP:  begin c.unit = U_FLOW; c.jump = 1'b1; end
            OP_JZ:   begin c.unit = U_FLOW; c.jump = 1'b1; c.need_zero = 1'b1; end
            OP_HALT: begin c.unit = U_FLOW; c.halt = 1'b1; end
            default: c.unit = U_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_prog_store.sv
module acc_prog_store #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           ld_en,
    input  logic [W-1:0]   ld_addr,
    input  logic [2*W-1:0] ld_word,
    input  logic [W-1:0]   rd_addr,
    output logic [2*W-1:0] rd_word
);
    localparam int DEPTH = 1 << W;

    logic [2*W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            cells[ld_addr] <= ld_word;
        end
    end

    assign rd_word = cells[rd_addr];
endmodule

// File: rtl/acc_data_store.sv
module acc_data_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         ld_en,
    input  logic [W-1:0] ld_addr,
    input  logic [W-1:0] ld_val,
    input  logic         core_we,
    input  logic [W-1:0] core_addr,
    input  logic [W-1:0] core_wdata,
    output logic [W-1:0] core_rdata,
    input  logic [W-1:0] peek_addr,
    output logic [W-1:0] peek_data
);
    localparam int DEPTH = 1 << W;

    logic [W-1:0] cells [DEPTH];

    // The load port wins when both request the same edge.
    always_ff @(posedge clk) begin
        if (ld_en) begin
            cells[ld_addr] <= ld_val;
        end else if (core_we) begin
            cells[core_addr] <= core_wdata;
        end
    end

    assign core_rdata = cells[core_addr];
    assign peek_data  = cells[peek_addr];
endmodule

// File: rtl/acc_decode.sv
module acc_decode #(
    parameter int W = 8
) (
    input  logic [2*W-1:0]  word,
    output acc_pkg::ctrl_t  ctrl,
    output logic [W-1:0]    arg
);
    logic [W-1:0] op_field;

    assign op_field = word[2*W-1:W];
    assign arg      = word[W-1:0];

    always_comb begin
        ctrl = acc_pkg::classify(32'(op_field));
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int W = 8
) (
    input  acc_pkg::alu_fn_e fn,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     y
);
    always_comb begin
        case (fn)
            acc_pkg::F_ADD: y = a + b;
            acc_pkg::F_SUB: y = a - b;
            acc_pkg::F_AND: y = a & b;
            default:        y = b;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld_prog_en,
    input  logic           ld_data_en,
    input  logic [W-1:0]   ld_addr,
    input  logic [2*W-1:0] ld_prog_word,
    input  logic [W-1:0]   ld_data_val,
    input  logic [W-1:0]   peek_addr,
    output logic [W-1:0]   peek_data,
    output logic [W-1:0]   pc_o,
    output logic [W-1:0]   acc_o,
    output logic [W-1:0]   in1_o,
    output logic [W-1:0]   in2_o,
    output logic           halted
);
    import acc_pkg::*;

    logic [W-1:0]   pc_q, acc_q, in1_q, in2_q;
    logic           halt_q;
    logic [2*W-1:0] cur_word;
    ctrl_t          ctrl;
    logic [W-1:0]   arg;
    logic [W-1:0]   alu_y;
    logic [W-1:0]   mem_addr;
    logic [W-1:0]   mem_rdata;
    logic           run;
    logic           take_jump;
    logic [W-1:0]   acc_next;

    assign run = !rst && !halt_q;

    acc_prog_store #(.W(W)) u_prog (
        .clk     (clk),
        .ld_en   (ld_prog_en && rst),
        .ld_addr (ld_addr),
        .ld_word (ld_prog_word),
        .rd_addr (pc_q),
        .rd_word (cur_word)
    );

    acc_decode #(.W(W)) u_dec (
        .word (cur_word),
        .ctrl (ctrl),
        .arg  (arg)
    );

    acc_alu #(.W(W)) u_alu (
        .fn (ctrl.fn),
        .a  (acc_q),
        .b  (arg),
        .y  (alu_y)
    );

    assign mem_addr = ctrl.indexed ? (in1_q + arg) : arg;

    acc_data_store #(.W(W)) u_data (
        .clk        (clk),
        .ld_en      (ld_data_en && rst),
        .ld_addr    (ld_addr),
        .ld_val     (ld_data_val),
        .core_we    (run && ctrl.mem_we),
        .core_addr  (mem_addr),
        .core_wdata (acc_q),
        .core_rdata (mem_rdata),
        .peek_addr  (peek_addr),
        .peek_data  (peek_data)
    );

    // Each opcode reaches exactly one unit; the accumulator source follows it.
    always_comb begin
        acc_next = (ctrl.unit == U_ALU) ? alu_y : mem_rdata;
    end

    assign take_jump = ctrl.jump && (!ctrl.need_zero || (acc_q == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            acc_q  <= '0;
            in1_q  <= '0;
            in2_q  <= '0;
            halt_q <= 1'b0;
        end else if (!halt_q) begin
            if (ctrl.acc_we) acc_q <= acc_next;
            if (ctrl.in1_we) in1_q <= acc_q;
            if (ctrl.in2_we) in2_q <= acc_q;
            if (ctrl.halt) begin
                halt_q <= 1'b1;
            end else if (take_jump) begin
                pc_q <= arg;
            end else begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end

    assign pc_o   = pc_q;
    assign acc_o  = acc_q;
    assign in1_o  = in1_q;
    assign in2_o  = in2_q;
    assign halted = halt_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           halted,
    input logic [W-1:0]   pc_o,
    input logic [W-1:0]   acc_o,
    input logic [W-1:0]   in1_o,
    input logic [W-1:0]   in2_o,
    input logic [2*W-1:0] cur_word
);
    logic [W-1:0] op_f;
    logic [W-1:0] arg_f;

    assign op_f  = cur_word[2*W-1:W];
    assign arg_f = cur_word[W-1:0];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && acc_o == '0 && in1_o == '0 && in2_o == '0 && !halted));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && op_f != W'(10) && op_f != W'(11) && op_f != W'(15))
        |=> (pc_o == W'($past(pc_o) + 1'b1)));

    // R3
    add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && op_f == W'(4))
        |=> (acc_o == W'($past(acc_o) + $past(arg_f))));

    // R7
    jmp_target_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && op_f == W'(10)) |=> (pc_o == $past(arg_f)));

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc_o) && $stable(acc_o)
                    && $stable(in1_o) && $stable(in2_o)));
endmodule

bind acc_core acc_core_chk #(.W(W)) u_chk (.*);

// File: tb/test_acc_core.sv
module test_acc_core;
    localparam int W = 8;
    localparam int CLK_P = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ld_prog_en = 1'b0;
    logic           ld_data_en = 1'b0;
    logic [W-1:0]   ld_addr = '0;
    logic [2*W-1:0] ld_prog_word = '0;
    logic [W-1:0]   ld_data_val = '0;
    logic [W-1:0]   peek_addr = '0;
    logic [W-1:0]   peek_data, pc_o, acc_o, in1_o, in2_o;
    logic           halted;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    acc_core #(.W(W)) i_acc_core (
        .clk(clk), .rst(rst), .ld_prog_en(ld_prog_en), .ld_data_en(ld_data_en),
        .ld_addr(ld_addr), .ld_prog_word(ld_prog_word), .ld_data_val(ld_data_val),
        .peek_addr(peek_addr), .peek_data(peek_data), .pc_o(pc_o), .acc_o(acc_o),
        .in1_o(in1_o), .in2_o(in2_o), .halted(halted)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put_p(input int addr, input int op, input int arg);
        ld_prog_en = 1'b1;
        ld_addr = W'(addr);
        ld_prog_word = {W'(op), W'(arg)};
        @(negedge clk);
        ld_prog_en = 1'b0;
    endtask

    task automatic put_d(input int addr, input int val);
        ld_data_en = 1'b1;
        ld_addr = W'(addr);
        ld_data_val = W'(val);
        @(negedge clk);
        ld_data_en = 1'b0;
    endtask

    task automatic hold_rst();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic go();
        rst = 1'b0;
    endtask

    task automatic steps(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic int peek(input int addr);
        return 0;
    endfunction

    task automatic read_cell(input int addr, output int val);
        peek_addr = W'(addr);
        #1;
        val = int'(peek_data);
    endtask

    task automatic t_reset();
        hold_rst();
        check("R1 pc after reset", int'(pc_o), 0);
        check("R1 acc after reset", int'(acc_o), 0);
        check("R1 in1 after reset", int'(in1_o), 0);
        check("R1 in2 after reset", int'(in2_o), 0);
        check("R1 halted after reset", int'(halted), 0);
    endtask

    task automatic t_alu();
        hold_rst();
        put_p(0, 3, 200);
        put_p(1, 4, 100);
        put_p(2, 5, 50);
        put_p(3, 6, 8'h0F);
        put_p(4, 15, 0);
        go();
        steps(1);
        check("R3 ldi", int'(acc_o), 200);
        check("R2 pc step", int'(pc_o), 1);
        steps(1);
        check("R3 add wraps", int'(acc_o), 44);
        steps(1);
        check("R3 sub wraps", int'(acc_o), 250);
        check("R2 pc step 3", int'(pc_o), 3);
        steps(1);
        check("R3 and", int'(acc_o), 10);
        steps(1);
        check("R8 halted", int'(halted), 1);
        check("R8 pc at halt", int'(pc_o), 4);
    endtask

    task automatic t_mem();
        int v;
        hold_rst();
        put_d(20, 77);
        put_d(21, 0);
        put_p(0, 1, 20);
        put_p(1, 4, 3);
        put_p(2, 2, 21);
        put_p(3, 7, 0);
        put_p(4, 3, 5);
        put_p(5, 8, 0);
        put_p(6, 15, 0);
        go();
        steps(1);
        check("R4 load", int'(acc_o), 77);
        steps(2);
        check("R4 store keeps acc", int'(acc_o), 80);
        steps(5);
        read_cell(21, v);
        check("R4 stored cell", v, 80);
        read_cell(20, v);
        check("R4 source cell", v, 77);
        check("R5 in1", int'(in1_o), 80);
        check("R5 in2", int'(in2_o), 5);
        check("R5 acc", int'(acc_o), 5);
    endtask

    task automatic t_index();
        hold_rst();
        put_d(3, 8'h33);
        put_d(4, 8'h44);
        put_p(0, 3, 250);
        put_p(1, 7, 0);
        put_p(2, 9, 9);
        put_p(3, 15, 0);
        go();
        steps(3);
        check("R6 indexed wrap", int'(acc_o), 8'h33);
        check("R6 in1", int'(in1_o), 250);
    endtask

    task automatic t_jump();
        hold_rst();
        put_p(0, 3, 0);
        put_p(1, 11, 4);
        put_p(2, 3, 99);
        put_p(3, 15, 0);
        put_p(4, 3, 1);
        put_p(5, 11, 2);
        put_p(6, 10, 8);
        put_p(7, 3, 77);
        put_p(8, 15, 0);
        go();
        steps(2);
        check("R7 jz taken", int'(pc_o), 4);
        steps(2);
        check("R7 jz not taken", int'(pc_o), 6);
        steps(1);
        check("R7 jmp", int'(pc_o), 8);
        steps(3);
        check("R7 final acc", int'(acc_o), 1);
        check("R7 halted", int'(halted), 1);
    endtask

    task automatic t_nop();
        int v;
        hold_rst();
        put_d(55, 11);
        put_d(1, 22);
        put_d(3, 33);
        put_p(0, 3, 9);
        put_p(1, 0, 55);
        put_p(2, 12, 1);
        put_p(3, 13, 3);
        put_p(4, 255, 3);
        put_p(5, 15, 0);
        go();
        steps(1);
        check("R9 setup acc", int'(acc_o), 9);
        steps(4);
        check("R9 pc advanced", int'(pc_o), 5);
        check("R9 acc kept", int'(acc_o), 9);
        check("R9 in1 kept", int'(in1_o), 0);
        check("R9 in2 kept", int'(in2_o), 0);
        read_cell(55, v);
        check("R9 cell 55", v, 11);
        read_cell(1, v);
        check("R9 cell 1", v, 22);
        read_cell(3, v);
        check("R9 cell 3", v, 33);
    endtask

    task automatic t_halt();
        int v;
        hold_rst();
        put_d(9, 5);
        put_p(0, 3, 42);
        put_p(1, 15, 0);
        put_p(2, 2, 9);
        put_p(3, 3, 1);
        go();
        steps(12);
        check("R8 still halted", int'(halted), 1);
        check("R8 pc frozen", int'(pc_o), 1);
        check("R8 acc frozen", int'(acc_o), 42);
        read_cell(9, v);
        check("R8 no store after halt", v, 5);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset leaves halt", int'(halted), 0);
        check("R1 reset pc", int'(pc_o), 0);
    endtask

    task automatic t_split();
        int v;
        hold_rst();
        put_p(0, 3, 8'h55);
        put_p(1, 2, 2);
        put_p(2, 4, 1);
        put_p(3, 15, 0);
        go();
        steps(4);
        check("R10 next instruction intact", int'(acc_o), 8'h56);
        read_cell(2, v);
        check("R10 data cell written", v, 8'h55);
        check("R10 halted at 3", int'(pc_o), 3);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_alu();
        t_mem();
        t_index();
        t_jump();
        t_nop();
        t_halt();
        t_split();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule